// File: doc/BRIEF.md
# Second-Stage Guest Address Page Walker

This block translates a guest physical address into a host physical address by walking a multi-level page table in memory. A request carries the guest virtual address, which is kept only for trap reporting, the guest physical address and an access type. Each request is paired with a configuration: the root table base, the number of levels and the index bits per level. The walker reads one table entry per level through a valid/ready memory port. A response on that port is a single beat with an error flag.

Before any memory traffic, the walker rejects guest addresses wider than the table can map. It then descends from the top level. The top level uses an index that is two bits wider than the lower levels. Each non-leaf entry is checked on the way down. A leaf entry is not judged here: the entry, its level and the access type go to a separate permission checker, together with the composed host address. Faults come back as one of two kinds: a guest page fault for bad table contents, or an access fault when the memory port reports an error on an entry read. Only one walk is in flight at a time.

Top module: `gw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `busy`=0, `rsp_valid`=0 and `mem_req_valid`=0.
- R2: With `cfg_levels`=0 the result kind is BARE (code 0) and `rsp_addr` equals the guest physical address. No memory read is made, and `rsp_valid` rises one cycle after the request is accepted.
- R3: The widest legal guest address is `cfg_levels`×`cfg_kbits`+2+12 bits. If any bit at or above that position is set, the result is a guest page fault (code 2). No memory read is made, and the result comes one cycle after acceptance.
- R4: The walk starts at level `cfg_levels`−1 with base `cfg_root`. At level i the index is taken from guest address bit 12+i×`cfg_kbits`. The index is `cfg_kbits` wide, or `cfg_kbits`+2 wide at the top level. The entry address is base + index×8.
- R5: A memory response with `mem_rsp_err`=1 ends the walk with an access fault (code 3).
- R6: An entry with any reserved bit [60:54] set ends the walk with a guest page fault.
- R7: An entry with V (bit 0) clear ends the walk with a guest page fault.
- R8: A non-leaf entry has V=1 and R, W, X (bits 1..3) clear. If it has any of U (bit 4), A (bit 6), D (bit 7), memory type (bits 62:61) or N (bit 63) set, the walk ends with a guest page fault. Otherwise the next base is PPN (bits 53:10) shifted left by 12.
- R9: A non-leaf entry found at level 0 gives a guest page fault.
- R10: A leaf entry (V=1 with any of R, W, X set) gives kind LEAF (code 1). The response carries the entry, the level and the request's access type. `rsp_addr` is PPN<<12 with its low 12+level×`cfg_kbits` bits taken from the guest address.
- R11: While a walk is in progress, `req_ready` is low and requests are ignored. A memory request stays asserted with a stable address until `mem_req_ready`.
- R12: `rsp_valid` is a one-cycle pulse. With it, `rsp_gva` and `rsp_gpa` echo the request, and a walk of N reads with an always-ready port responding one cycle later completes 1+2N cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request taken |
| req_gva | input | GVA_W | Guest virtual address for trap reporting |
| req_gpa | input | GPA_W | Guest physical address to translate |
| req_type | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| cfg_root | input | PA_W | Root table base address |
| cfg_levels | input | LVL_W | Number of table levels, 0 disables translation |
| cfg_kbits | input | KB_W | Index bits per level |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W | Entry read from memory |
| mem_rsp_err | input | 1 | Read failed (outside memory or protection) |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_kind | output | 2 | 0 bare, 1 leaf, 2 guest page fault, 3 access fault |
| rsp_addr | output | PA_W | Host address (bare or leaf) |
| rsp_pte | output | PTE_W | Last entry read |
| rsp_level | output | LVL_W | Level of the last entry |
| rsp_type | output | 2 | Echoed access type |
| rsp_gva | output | GVA_W | Echoed guest virtual address |
| rsp_gpa | output | GPA_W | Echoed guest physical address |

## Verification
Results that need no memory read, bare pass-through and out-of-range rejection, are due one cycle after the accepting edge. Each table read adds two cycles: one to issue the read and one for the model's response. A walk of N reads therefore ends 1+2N cycles after acceptance. The bench counts edges from acceptance to `rsp_valid`, sampling at the falling edge, and compares the count with these figures. It also checks the number of reads and the address of every entry read. In the back-pressure case the extra cycles with `mem_req_ready` low are allowed for, and the request is checked for stability at each of those cycles.

// File: rtl/gw_pkg.sv
// Shared types for the guest address walker.
// Assumes 4 KiB pages and the 64-bit or 32-bit entry layouts used by gw_pte_decode.
package gw_pkg;
    localparam int PG_SHIFT = 12;

    typedef enum logic [1:0] {
        RES_BARE = 2'd0,
        RES_LEAF = 2'd1,
        RES_GPF  = 2'd2,
        RES_ACCF = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic       v;
        logic       r;
        logic       w;
        logic       x;
        logic       u;
        logic       a;
        logic       d;
        logic       n;
        logic [1:0] mtype;
        logic       rsvd;
    } pte_flags_t;
endpackage

// File: rtl/gw_range_chk.sv
// Out-of-range pre-check: flags a guest address with a set bit at or
// above levels*kbits + WIDEN + page shift. Pure combinational.
// Assumes GPA_W < 256 so that 8-bit positions suffice.
module gw_range_chk
    import gw_pkg::*;
#(
    parameter int GPA_W = 48,
    parameter int LVL_W = 3,
    parameter int KB_W  = 4,
    parameter int WIDEN = 2
) (
    input  logic [GPA_W-1:0] gpa,
    input  logic [LVL_W-1:0] levels,
    input  logic [KB_W-1:0]  kbits,
    output logic             too_wide
);
    logic [7:0] max_bits;

    // Scan every guest bit against the legal width.
    always_comb begin
        max_bits = 8'(levels) * 8'(kbits) + 8'(WIDEN) + 8'(PG_SHIFT);
        too_wide = 1'b0;
        for (int b = 0; b < GPA_W; b++) begin
            if ((8'(b) >= max_bits) && gpa[b]) too_wide = 1'b1;
        end
    end
endmodule

// File: rtl/gw_index.sv
// Entry address generator: selects the level's index field from the guest
// address (wider at the top level) and scales it by the entry size.
// Assumes PTE_BYTES is a power of two.
module gw_index
    import gw_pkg::*;
#(
    parameter int GPA_W     = 48,
    parameter int PA_W      = 56,
    parameter int LVL_W     = 3,
    parameter int KB_W      = 4,
    parameter int WIDEN     = 2,
    parameter int PTE_BYTES = 8
) (
    input  logic [GPA_W-1:0] gpa,
    input  logic [PA_W-1:0]  base,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] top,
    input  logic [KB_W-1:0]  kbits,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int ENT_SH = $clog2(PTE_BYTES);

    logic [7:0]       shamt;
    logic [7:0]       fwidth;
    logic [GPA_W-1:0] field;

    // Extract the index and form base + index * entry size.
    always_comb begin
        shamt      = 8'(PG_SHIFT) + 8'(lvl) * 8'(kbits);
        fwidth     = 8'(kbits) + ((lvl == top) ? 8'(WIDEN) : 8'd0);
        field      = (gpa >> shamt) & ((GPA_W'(1) << fwidth) - GPA_W'(1));
        entry_addr = base + (PA_W'(field) << ENT_SH);
    end
endmodule

// File: rtl/gw_pte_decode.sv
// Entry field decoder. A generate branch selects the 64-bit layout
// (reserved, memory-type and N fields present) or the 32-bit layout.
// Assumes PPN_W is at least the entry's native PPN width.
module gw_pte_decode
    import gw_pkg::*;
#(
    parameter int PTE_BYTES = 8,
    parameter int PPN_W     = 44,
    localparam int PTE_W    = PTE_BYTES * 8
) (
    input  logic [PTE_W-1:0] pte,
    output pte_flags_t       flags,
    output logic [PPN_W-1:0] ppn
);
    generate
        if (PTE_BYTES == 8) begin : g_wide
            // 64-bit entry: all fields present.
            always_comb begin
                flags = '{v: pte[0], r: pte[1], w: pte[2], x: pte[3], u: pte[4],
                          a: pte[6], d: pte[7], n: pte[63], mtype: pte[62:61],
                          rsvd: |pte[60:54]};
                ppn   = PPN_W'(pte[53:10]);
            end
        end else begin : g_narrow
            // 32-bit entry: no reserved, memory-type or N fields.
            always_comb begin
                flags = '{v: pte[0], r: pte[1], w: pte[2], x: pte[3], u: pte[4],
                          a: pte[6], d: pte[7], n: 1'b0, mtype: 2'b00,
                          rsvd: 1'b0};
                ppn   = PPN_W'(pte[31:10]);
            end
        end
    endgenerate
endmodule

// File: rtl/gw_walker.sv
// Second-stage walker top. Accepts one request when idle, screens it
// (bare mode, width pre-check), then reads one entry per level and
// checks non-leaf entries. Leaves go out with level and type for a
// separate permission checker. Assumes the memory answers each accepted
// read with exactly one response beat and never answers otherwise.
module gw_walker
    import gw_pkg::*;
#(
    parameter int GVA_W     = 64,
    parameter int GPA_W     = 48,
    parameter int PA_W      = 56,
    parameter int LVL_W     = 3,
    parameter int KB_W      = 4,
    parameter int WIDEN     = 2,
    parameter int PTE_BYTES = 8,
    localparam int PTE_W    = PTE_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [GVA_W-1:0] req_gva,
    input  logic [GPA_W-1:0] req_gpa,
    input  logic [1:0]       req_type,
    input  logic [PA_W-1:0]  cfg_root,
    input  logic [LVL_W-1:0] cfg_levels,
    input  logic [KB_W-1:0]  cfg_kbits,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             busy,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [PA_W-1:0]  rsp_addr,
    output logic [PTE_W-1:0] rsp_pte,
    output logic [LVL_W-1:0] rsp_level,
    output logic [1:0]       rsp_type,
    output logic [GVA_W-1:0] rsp_gva,
    output logic [GPA_W-1:0] rsp_gpa
);
    localparam int PPN_W = PA_W - PG_SHIFT;

    walk_st_e         state;
    logic [GVA_W-1:0] gva_q;
    logic [GPA_W-1:0] gpa_q;
    logic [1:0]       type_q;
    logic [KB_W-1:0]  kbits_q;
    logic [LVL_W-1:0] top_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PA_W-1:0]  base_q;
    res_e             kind_q;
    logic [PA_W-1:0]  addr_q;
    logic [PTE_W-1:0] pte_q;

    logic             too_wide;
    pte_flags_t       fl;
    logic [PPN_W-1:0] ppn;
    logic             is_table;
    logic             table_dirty;
    logic [7:0]       page_bits;
    logic [PA_W-1:0]  page_mask;
    logic [PA_W-1:0]  leaf_addr;

    gw_range_chk #(.GPA_W(GPA_W), .LVL_W(LVL_W), .KB_W(KB_W), .WIDEN(WIDEN)) u_range (
        .gpa(req_gpa), .levels(cfg_levels), .kbits(cfg_kbits), .too_wide(too_wide)
    );

    gw_index #(.GPA_W(GPA_W), .PA_W(PA_W), .LVL_W(LVL_W), .KB_W(KB_W),
               .WIDEN(WIDEN), .PTE_BYTES(PTE_BYTES)) u_index (
        .gpa(gpa_q), .base(base_q), .lvl(lvl_q), .top(top_q), .kbits(kbits_q),
        .entry_addr(mem_req_addr)
    );

    gw_pte_decode #(.PTE_BYTES(PTE_BYTES), .PPN_W(PPN_W)) u_dec (
        .pte(mem_rsp_data), .flags(fl), .ppn(ppn)
    );

    // Classify the returned entry and compose the leaf host address.
    always_comb begin
        is_table    = fl.v && !fl.r && !fl.w && !fl.x;
        table_dirty = fl.d || fl.a || fl.u || fl.n || (|fl.mtype);
        page_bits   = 8'(PG_SHIFT) + 8'(lvl_q) * 8'(kbits_q);
        page_mask   = (PA_W'(1) << page_bits) - PA_W'(1);
        leaf_addr   = ({ppn, {PG_SHIFT{1'b0}}} & ~page_mask) | (PA_W'(gpa_q) & page_mask);
    end

    // Walk sequencer: accept, issue, wait, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            gva_q   <= '0;
            gpa_q   <= '0;
            type_q  <= '0;
            kbits_q <= '0;
            top_q   <= '0;
            lvl_q   <= '0;
            base_q  <= '0;
            kind_q  <= RES_BARE;
            addr_q  <= '0;
            pte_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    gva_q   <= req_gva;
                    gpa_q   <= req_gpa;
                    type_q  <= req_type;
                    kbits_q <= cfg_kbits;
                    base_q  <= cfg_root;
                    pte_q   <= '0;
                    addr_q  <= '0;
                    top_q   <= cfg_levels - 1'b1;
                    lvl_q   <= cfg_levels - 1'b1;
                    if (cfg_levels == '0) begin
                        kind_q <= RES_BARE;
                        addr_q <= PA_W'(req_gpa);
                        lvl_q  <= '0;
                        state  <= ST_DONE;
                    end else if (too_wide) begin
                        kind_q <= RES_GPF;
                        state  <= ST_DONE;
                    end else begin
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    pte_q <= mem_rsp_data;
                    state <= ST_DONE;
                    if (mem_rsp_err) begin
                        kind_q <= RES_ACCF;
                    end else if (fl.rsvd || !fl.v) begin
                        kind_q <= RES_GPF;
                    end else if (is_table) begin
                        if (table_dirty || (lvl_q == '0)) begin
                            kind_q <= RES_GPF;
                        end else begin
                            base_q <= {ppn, {PG_SHIFT{1'b0}}};
                            lvl_q  <= lvl_q - 1'b1;
                            state  <= ST_ISSUE;
                        end
                    end else begin
                        kind_q <= RES_LEAF;
                        addr_q <= leaf_addr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign busy          = (state != ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign rsp_valid     = (state == ST_DONE);
    assign rsp_kind      = kind_q;
    assign rsp_addr      = addr_q;
    assign rsp_pte       = pte_q;
    assign rsp_level     = lvl_q;
    assign rsp_type      = type_q;
    assign rsp_gva       = gva_q;
    assign rsp_gpa       = gpa_q;
endmodule

// File: rtl/gw_walker_chk.sv
// Protocol checker for gw_walker, attached by bind below.
// Assumes the synchronous active-low reset of the walker.
module gw_walker_chk #(
    parameter int GPA_W = 48,
    parameter int PA_W  = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             mem_rsp_err,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [PA_W-1:0]  rsp_addr,
    input logic [GPA_W-1:0] rsp_gpa
);
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> busy); // R11
    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req_valid); // R1
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R12
    AST_BARE_PASS: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && (rsp_kind == 2'd0) |-> rsp_addr == PA_W'(rsp_gpa)); // R2
    AST_ACCF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && (rsp_kind == 2'd3) |-> $past(mem_rsp_valid && mem_rsp_err)); // R5
endmodule

bind gw_walker gw_walker_chk #(.GPA_W(GPA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_gpa(rsp_gpa)
);

// File: tb/gw_walker_tb.sv
`timescale 1ns/1ps
// Bench for gw_walker: sweeps of small table configurations with
// expected results and latencies computed arithmetically.
module gw_walker_tb;
    localparam logic [55:0] MEM_TOP = 56'h10_0000;
    localparam logic [63:0] FV = 64'h1, FR = 64'h2, FW = 64'h4, FX = 64'h8,
                            FU = 64'h10, FA = 64'h40, FD = 64'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_gva = '0;
    logic [47:0] req_gpa = '0;
    logic [1:0]  req_type = '0;
    logic [55:0] cfg_root = '0;
    logic [2:0]  cfg_levels = '0;
    logic [3:0]  cfg_kbits = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        mem_rsp_err;
    logic        busy, rsp_valid;
    logic [1:0]  rsp_kind, rsp_type;
    logic [55:0] rsp_addr;
    logic [63:0] rsp_pte, rsp_gva;
    logic [2:0]  rsp_level;
    logic [47:0] rsp_gpa;

    int checks = 0;
    int errors = 0;
    logic stall_on = 1'b0;
    logic pend = 1'b0;
    logic [63:0] rdata = '0;
    logic rerr = 1'b0;
    int nreq = 0;
    logic [55:0] alog [8];
    logic [63:0] pmem [longint unsigned];

    // Captured result of the last walk.
    int lat, nrd, n0;
    logic [1:0]  k_o;
    logic [55:0] a_o;
    logic [63:0] p_o, gva_o;
    logic [2:0]  l_o;
    logic [47:0] gpa_o;
    logic [1:0]  t_o;

    always #2.5 clk = ~clk;

    assign mem_req_ready = !stall_on;
    assign mem_rsp_valid = pend;
    assign mem_rsp_data  = rdata;
    assign mem_rsp_err   = rerr;

    gw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_gva(req_gva), .req_gpa(req_gpa), .req_type(req_type),
        .cfg_root(cfg_root), .cfg_levels(cfg_levels), .cfg_kbits(cfg_kbits),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
        .rsp_pte(rsp_pte), .rsp_level(rsp_level), .rsp_type(rsp_type),
        .rsp_gva(rsp_gva), .rsp_gpa(rsp_gpa)
    );

    // Memory model: one-beat response the cycle after acceptance.
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                pend  <= 1'b1;
                rerr  <= (mem_req_addr >= MEM_TOP);
                rdata <= pmem.exists(longint'(mem_req_addr)) ? pmem[longint'(mem_req_addr)] : 64'h0;
                alog[nreq % 8] <= mem_req_addr;
                nreq  <= nreq + 1;
            end
        end
    end

    function automatic logic [63:0] mk_pte(input logic [63:0] ppn, input logic [63:0] fl);
        return (ppn << 10) | fl;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] gva, input logic [47:0] gpa, input logic [1:0] ty);
        @(negedge clk);
        req_gva = gva; req_gpa = gpa; req_type = ty; req_valid = 1'b1; n0 = nreq;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        k_o = rsp_kind; a_o = rsp_addr; p_o = rsp_pte; l_o = rsp_level;
        gva_o = rsp_gva; gpa_o = rsp_gpa; t_o = rsp_type;
        nrd = nreq - n0;
    endtask

    // Populate a two-level table: 16 root pointers, 4 leaves under each.
    task automatic build_tables();
        pmem.delete();
        for (int r = 0; r < 16; r++) begin
            pmem[longint'(64'h1000 + r * 8)] = mk_pte(64'(2 + r), FV);
            for (int j = 0; j < 4; j++)
                pmem[longint'(64'h2000 + r * 64'h1000 + j * 8)] = mk_pte(64'(64'h100 + r * 4 + j), FV | FR | FA | FU);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset.
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R2: bare pass-through sweep.
        cfg_levels = 3'd0; cfg_kbits = 4'd9; cfg_root = 56'h1000;
        for (int b = 0; b < 50; b++) begin
            logic [47:0] g;
            g = (b < 48) ? (48'h1 << b) : ((b == 48) ? 48'hFFFF_FFFF_FFFF : 48'h1234_5678_9ABC);
            walk(~64'(g), g, 2'd1);
            chk("R2 kind", 64'(k_o), 64'd0);
            chk("R2 addr", 64'(a_o), 64'(g));
            chk("R2 reads", 64'(nrd), 64'd0);
            chk("R2 latency", 64'(lat), 64'd1);
        end

        // R3: width pre-check, levels 2, 2 bits per level => 18 bits.
        pmem.delete();
        cfg_levels = 3'd2; cfg_kbits = 4'd2; cfg_root = 56'h1000;
        for (int b = 0; b < 48; b++) begin
            logic [47:0] g;
            g = 48'h1 << b;
            walk(64'hA5A5_0000_0000_0000 | 64'(b), g, 2'd0);
            chk("R3 kind", 64'(k_o), 64'd2);
            chk("R3 reads", 64'(nrd), (b >= 18) ? 64'd0 : 64'd1);
            chk("R3 latency", 64'(lat), (b >= 18) ? 64'd1 : 64'd3);
            chk("R12 gva echo", gva_o, 64'hA5A5_0000_0000_0000 | 64'(b));
            chk("R12 gpa echo", 64'(gpa_o), 64'(g));
        end

        // R4 / R10: full index sweep of the two-level table.
        build_tables();
        for (int r = 0; r < 16; r++) begin
            for (int j = 0; j < 4; j++) begin
                logic [47:0] g;
                logic [63:0] ppn, off;
                off = 64'((r * 37 + j * 101) & 12'hFFF);
                g   = 48'((r << 14) | (j << 12)) | 48'(off);
                ppn = 64'(64'h100 + r * 4 + j);
                walk(64'(r * 16 + j), g, 2'((r + j) % 3));
                chk("R10 kind", 64'(k_o), 64'd1);
                chk("R10 level", 64'(l_o), 64'd0);
                chk("R10 addr", 64'(a_o), (ppn << 12) | off);
                chk("R10 pte", p_o, mk_pte(ppn, FV | FR | FA | FU));
                chk("R10 type", 64'(t_o), 64'((r + j) % 3));
                chk("R4 reads", 64'(nrd), 64'd2);
                chk("R4 root addr", 64'(alog[n0 % 8]), 64'(64'h1000 + r * 8));
                chk("R8 next addr", 64'(alog[(n0 + 1) % 8]), 64'(64'h2000 + r * 64'h1000 + j * 8));
                chk("R12 latency", 64'(lat), 64'd5);
            end
        end

        // R10: superpage leaf at level 1.
        pmem[longint'(64'h1000 + 3 * 8)] = mk_pte(64'h400, FV | FR | FX | FA | FU);
        walk(64'h33, 48'((3 << 14) | 14'h2ABC), 2'd0);
        chk("R10 super kind", 64'(k_o), 64'd1);
        chk("R10 super level", 64'(l_o), 64'd1);
        chk("R10 super addr", 64'(a_o), 64'h40_0000 | 64'h2ABC);
        chk("R10 super reads", 64'(nrd), 64'd1);
        chk("R12 super latency", 64'(lat), 64'd3);

        // R8: forbidden bits on a pointer.
        for (int t = 0; t < 6; t++) begin
            logic [63:0] bad;
            case (t)
                0: bad = FD;
                1: bad = FA;
                2: bad = FU;
                3: bad = 64'h1 << 63;
                4: bad = 64'h1 << 61;
                default: bad = 64'h1 << 62;
            endcase
            pmem[longint'(64'h1000 + 5 * 8)] = mk_pte(64'd7, FV) | bad;
            walk(64'h55, 48'(5 << 14), 2'd1);
            chk("R8 kind", 64'(k_o), 64'd2);
            chk("R8 reads", 64'(nrd), 64'd1);
        end
        pmem[longint'(64'h1000 + 5 * 8)] = mk_pte(64'd7, FV);

        // R6: reserved bits on a leaf and on a pointer.
        pmem[longint'(64'h2000 + 6 * 64'h1000 + 8)] = mk_pte(64'h119, FV | FR | FA | FU) | (64'h1 << 54);
        walk(64'h61, 48'((6 << 14) | (1 << 12)), 2'd1);
        chk("R6 leaf kind", 64'(k_o), 64'd2);
        chk("R6 leaf reads", 64'(nrd), 64'd2);
        pmem[longint'(64'h1000 + 9 * 8)] = mk_pte(64'd11, FV) | (64'h1 << 60);
        walk(64'h91, 48'(9 << 14), 2'd1);
        chk("R6 ptr kind", 64'(k_o), 64'd2);
        chk("R6 ptr reads", 64'(nrd), 64'd1);

        // R7: invalid leaf entry.
        pmem[longint'(64'h2000 + 10 * 64'h1000 + 16)] = mk_pte(64'h12A, FR | FA | FU);
        walk(64'hA2, 48'((10 << 14) | (2 << 12)), 2'd1);
        chk("R7 kind", 64'(k_o), 64'd2);
        chk("R7 reads", 64'(nrd), 64'd2);

        // R9: pointer found at level 0.
        pmem[longint'(64'h2000 + 7 * 64'h1000 + 16)] = mk_pte(64'd3, FV);
        walk(64'h72, 48'((7 << 14) | (2 << 12)), 2'd1);
        chk("R9 kind", 64'(k_o), 64'd2);
        chk("R9 reads", 64'(nrd), 64'd2);
        chk("R9 latency", 64'(lat), 64'd5);

        // R5: memory error at root and at second level.
        cfg_root = MEM_TOP;
        walk(64'h5, 48'h0, 2'd1);
        chk("R5 root kind", 64'(k_o), 64'd3);
        chk("R5 root latency", 64'(lat), 64'd3);
        cfg_root = 56'h1000;
        pmem[longint'(64'h1000 + 8 * 8)] = mk_pte(64'h200, FV);
        walk(64'h6, 48'(8 << 14), 2'd1);
        chk("R5 second kind", 64'(k_o), 64'd3);
        chk("R5 second reads", 64'(nrd), 64'd2);

        // R3 / R4: three levels of 3 bits => 23-bit limit, 5-bit root index at bit 18.
        cfg_levels = 3'd3; cfg_kbits = 4'd3;
        walk(64'h7, 48'h1 << 23, 2'd0);
        chk("R3 l3 kind", 64'(k_o), 64'd2);
        chk("R3 l3 reads", 64'(nrd), 64'd0);
        walk(64'h8, 48'((5'h13 << 18) | 18'h3_F123), 2'd0);
        chk("R4 l3 root addr", 64'(alog[n0 % 8]), 64'h1000 + 64'h13 * 8);
        chk("R4 l3 kind", 64'(k_o), 64'd2);

        // R11: back-pressure and ignored request while busy.
        build_tables();
        cfg_levels = 3'd2; cfg_kbits = 4'd2;
        stall_on = 1'b1;
        @(negedge clk);
        req_gva = 64'h11; req_gpa = 48'((1 << 14) | (1 << 12) | 12'h0AB); req_valid = 1'b1; n0 = nreq;
        @(posedge clk);
        @(negedge clk);
        req_gpa = 48'((4 << 14) | 12'h777);
        for (int c = 0; c < 4; c++) begin
            chk("R11 mem hold", 64'(mem_req_valid), 64'd1);
            chk("R11 mem addr", 64'(mem_req_addr), 64'h1008);
            chk("R11 not ready", 64'(req_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        stall_on = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk("R11 kind", 64'(rsp_kind), 64'd1);
        chk("R11 addr", 64'(rsp_addr), (64'h105 << 12) | 64'h0AB);
        chk("R11 gpa", 64'(rsp_gpa), 64'((1 << 14) | (1 << 12) | 12'h0AB));
        for (int c = 0; c < 10; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R11 no second walk", 64'(rsp_valid | mem_req_valid), 64'd0);
        end
        chk("R11 reads", 64'(nreq - n0), 64'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule